// File: doc/BRIEF.md
# Random TLB Index Generator

This block picks a pseudo-random replacement slot for a software-managed translation buffer. A free-running 32-bit Galois shift register supplies raw bits. On each request the block advances that register once and folds the value into the window of entries above the wired boundary. The window runs from the wired count up to the last entry. Entries below the boundary are never chosen.

The fold is a remainder against the window size, computed one dividend bit per clock. If the folded slot equals the slot handed out last time, the register steps again and the fold repeats until a different slot appears. The result is presented with a one-cycle valid pulse. While a computation runs, a busy flag is high and any further request strobe is ignored.

Top module: `rand_way_picker`

## Requirements
- R1: After reset, `idx_o` is 0, `valid_o` is 0 and `busy_o` is 0.
- R2: The generator state starts at 1. Each step shifts it right by one. When the bit shifted out was 1, the shifted value is XORed with 0xD0000001. Every attempt to form a slot uses exactly one step.
- R3: A candidate slot is (state mod (ENTRIES - w)) + w. Here w is the effective wired count taken at the accepted request.
- R4: The effective wired count is `wired_i` clamped to at most ENTRIES-2. A `wired_i` of ENTRIES-2 or more therefore yields slots ENTRIES-2 and ENTRIES-1 only.
- R5: A slot equal to the previously returned slot is never returned. The previous slot counts as 0 right after reset. On a repeat the generator steps again until the candidate differs.
- R6: `valid_o` is high for exactly one cycle when a result is ready. `idx_o` changes only in that cycle and holds its value until the next result.
- R7: A request accepted while idle raises `busy_o` on the next cycle. `busy_o` stays high until the result cycle, where it is low. A request seen while `busy_o` is high has no effect: it does not step the generator and does not change the wired count in use.
- R8: Every returned slot lies in the range from w up to ENTRIES-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request strobe for a new slot, taken only while idle |
| wired_i | input | $clog2(ENTRIES+1) | Number of wired entries at the bottom of the buffer |
| idx_o | output | $clog2(ENTRIES) | Last returned slot |
| valid_o | output | 1 | One-cycle pulse marking a new slot on idx_o |
| busy_o | output | 1 | High while a slot is being computed |

## Verification
The bench builds the block with ENTRIES = 16, a 32-bit generator, tap constant 0xD0000001 and seed 1. With ENTRIES = 16 the 5-bit wired input can be driven past the clamp point (15, 16 and 31), so the two-slot window is reachable. In that window the no-repeat rule forces strict alternation. A wired count of 0 exercises the full sixteen-slot window, where repeats and retries occur naturally in the first few dozen draws. With the 32-bit generator and a 16-entry window, each draw takes about 34 cycles, so held-off request strobes can be kept inside a single computation.

// File: rtl/rw_pkg.sv
package rw_pkg;

  typedef enum logic {
    RW_IDLE = 1'b0,
    RW_RUN  = 1'b1
  } rw_state_e;

endpackage

// File: rtl/rw_lfsr.sv
// Galois shift register, one step per enable, right-shifting.
module rw_lfsr #(
  parameter int unsigned      W    = 32,
  parameter logic [W-1:0]     TAP  = 32'hD000_0001,
  parameter logic [W-1:0]     SEED = 32'h0000_0001
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_i,
  output logic [W-1:0] next_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] stepped;

  always_comb begin
    stepped = (state_q >> 1) ^ (state_q[0] ? TAP : '0);
    next_o  = stepped;
    state_d = state_q;
    if (step_i) begin
      state_d = stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEED;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/rw_modred.sv
// Serial remainder: one dividend bit per cycle, MSB first, restoring subtract.
module rw_modred #(
  parameter int unsigned DW = 32,
  parameter int unsigned SW = 5,
  localparam int unsigned CW = (DW > 1) ? $clog2(DW) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] span_i,
  output logic [SW-1:0] rem_o,
  output logic          done_o
);

  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [DW-1:0] sreg_q, sreg_d;
  logic [SW-1:0] rem_q, rem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;
  logic [SW:0]   shifted;
  logic          fits;

  always_comb begin
    shifted = {rem_q, sreg_q[DW-1]};
    fits    = shifted >= {1'b0, span_i};
    sreg_d  = sreg_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    run_d   = run_q;
    done_d  = 1'b0;
    if (start_i) begin
      sreg_d = dividend_i;
      rem_d  = '0;
      cnt_d  = '0;
      run_d  = 1'b1;
    end else if (run_q) begin
      sreg_d = sreg_q << 1;
      if (fits) begin
        rem_d = SW'(shifted - {1'b0, span_i});
      end else begin
        rem_d = SW'(shifted);
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      sreg_q <= sreg_d;
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign rem_o  = rem_q;
  assign done_o = done_q;

endmodule

// File: rtl/rand_way_picker.sv
module rand_way_picker
  import rw_pkg::*;
#(
  parameter int unsigned        ENTRIES = 16,
  parameter int unsigned        LFSR_W  = 32,
  parameter logic [LFSR_W-1:0]  TAP     = 32'hD000_0001,
  parameter logic [LFSR_W-1:0]  SEED    = 32'h0000_0001,
  localparam int unsigned       IDX_W   = $clog2(ENTRIES),
  localparam int unsigned       CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] wired_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             valid_o,
  output logic             busy_o
);

  localparam logic [CNT_W-1:0] MAX_WIRED = CNT_W'(ENTRIES - 2);
  localparam logic [CNT_W-1:0] SIZE      = CNT_W'(ENTRIES);

  rw_state_e        state_q, state_d;
  logic [CNT_W-1:0] weff_q, weff_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             valid_q, valid_d;
  logic             step_en;
  logic             div_start;
  logic [LFSR_W-1:0] lfsr_next;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] rem;
  logic             div_done;
  logic [IDX_W-1:0] cand;
  logic [CNT_W-1:0] wired_clamped;

  rw_lfsr #(
    .W    (LFSR_W),
    .TAP  (TAP),
    .SEED (SEED)
  ) u_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (step_en),
    .next_o (lfsr_next)
  );

  rw_modred #(
    .DW (LFSR_W),
    .SW (CNT_W)
  ) u_modred (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (lfsr_next),
    .span_i     (span),
    .rem_o      (rem),
    .done_o     (div_done)
  );

  always_comb begin
    wired_clamped = (wired_i > MAX_WIRED) ? MAX_WIRED : wired_i;
    span          = SIZE - weff_q;
    cand          = IDX_W'(rem) + IDX_W'(weff_q);
    state_d       = state_q;
    weff_d        = weff_q;
    idx_d         = idx_q;
    valid_d       = 1'b0;
    step_en       = 1'b0;
    div_start     = 1'b0;
    unique case (state_q)
      RW_IDLE: begin
        if (req_i) begin
          step_en   = 1'b1;
          div_start = 1'b1;
          weff_d    = wired_clamped;
          state_d   = RW_RUN;
        end
      end
      RW_RUN: begin
        if (div_done) begin
          if (cand == idx_q) begin
            step_en   = 1'b1;
            div_start = 1'b1;
          end else begin
            idx_d   = cand;
            valid_d = 1'b1;
            state_d = RW_IDLE;
          end
        end
      end
      default: state_d = RW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RW_IDLE;
      weff_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      weff_q  <= weff_d;
      idx_q   <= idx_d;
      valid_q <= valid_d;
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign busy_o  = (state_q == RW_RUN);

endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
  parameter int unsigned  ENTRIES = 16,
  localparam int unsigned IDX_W   = $clog2(ENTRIES),
  localparam int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic [CNT_W-1:0] wired_i,
  input logic [IDX_W-1:0] idx_o,
  input logic             valid_o,
  input logic             busy_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ENTRIES - 2);

  logic [IDX_W-1:0] prev_q;
  logic [CNT_W-1:0] win_lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      win_lo_q <= '0;
    end else begin
      if (valid_o) begin
        prev_q <= idx_o;
      end
      if (req_i && !busy_o) begin
        win_lo_q <= (wired_i > LIMIT) ? LIMIT : wired_i;
      end
    end
  end

  // R5
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (idx_o != prev_q));

  // R8
  in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (CNT_W'(idx_o) >= win_lo_q));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  // R6
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(idx_o));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !busy_o) |=> busy_o);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> !busy_o);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> valid_o);

endmodule

bind rand_way_picker rw_checker #(.ENTRIES(ENTRIES)) u_rw_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .wired_i (wired_i),
  .idx_o   (idx_o),
  .valid_o (valid_o),
  .busy_o  (busy_o)
);

// File: tb/test_rand_way_picker.sv
`timescale 1ns/1ps
module test_rand_way_picker;

  localparam int unsigned ENT   = 16;
  localparam int unsigned IDX_W = $clog2(ENT);
  localparam int unsigned CNT_W = $clog2(ENT + 1);

  logic             clk;
  logic             rst_n;
  logic             req_i;
  logic [CNT_W-1:0] wired_i;
  logic [IDX_W-1:0] idx_o;
  logic             valid_o;
  logic             busy_o;

  int checks;
  int errors;
  int cycles;

  logic [31:0] m_lfsr;
  int          m_last;

  rand_way_picker #(.ENTRIES(ENT)) i_rand_way_picker (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (req_i),
    .wired_i (wired_i),
    .idx_o   (idx_o),
    .valid_o (valid_o),
    .busy_o  (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL R6 watchdog: actual no finish expected finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] v);
    return (v >> 1) ^ (v[0] ? 32'hD000_0001 : 32'h0);
  endfunction

  function automatic int clamp(input int w);
    return (w > ENT - 2) ? ENT - 2 : w;
  endfunction

  task automatic model_next(input int w, output int exp);
    int weff;
    int cand;
    weff = clamp(w);
    do begin
      m_lfsr = step(m_lfsr);
      cand = int'(m_lfsr % 32'(ENT - weff)) + weff;
    end while (cand == m_last);
    m_last = cand;
    exp = cand;
  endtask

  // Issue one request and check the returned slot.
  task automatic draw(input int w, input string tag);
    int exp;
    int prev;
    int n;
    prev = m_last;
    model_next(w, exp);
    @(negedge clk);
    req_i   = 1'b1;
    wired_i = CNT_W'(w);
    @(negedge clk);
    req_i = 1'b0;
    check(busy_o == 1'b1, "R7 busy after accept", int'(busy_o), 1);
    n = 0;
    while (!valid_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(valid_o == 1'b1, "R6 result ready", int'(valid_o), 1);
    check(int'(idx_o) == exp, tag, int'(idx_o), exp);
    check(int'(idx_o) != prev, "R5 differs from previous", int'(idx_o), prev);
    check(int'(idx_o) >= clamp(w) && int'(idx_o) < ENT, "R8 in window",
          int'(idx_o), clamp(w));
    check(busy_o == 1'b0, "R7 idle at result", int'(busy_o), 0);
    @(negedge clk);
    check(valid_o == 1'b0, "R6 single pulse", int'(valid_o), 0);
    check(int'(idx_o) == exp, "R6 index held", int'(idx_o), exp);
  endtask

  task automatic t_reset();
    check(idx_o == '0, "R1 idx reset", int'(idx_o), 0);
    check(valid_o == 1'b0, "R1 valid reset", int'(valid_o), 0);
    check(busy_o == 1'b0, "R1 busy reset", int'(busy_o), 0);
  endtask

  task automatic t_full_range();
    for (int i = 0; i < 24; i++) begin
      draw(0, "R2 R3 full window sequence");
    end
  endtask

  task automatic t_mid_wired();
    for (int i = 0; i < 10; i++) begin
      draw(5, "R3 window above 5");
    end
    for (int i = 0; i < 6; i++) begin
      draw(ENT - 2, "R3 window at limit");
    end
  endtask

  task automatic t_clamp();
    int a;
    for (int i = 0; i < 6; i++) begin
      draw(ENT - 1, "R4 clamp from 15");
      a = int'(idx_o);
      draw(ENT, "R4 clamp from 16");
      check(int'(idx_o) != a, "R4 R5 alternation", int'(idx_o), a);
      draw(31, "R4 clamp from 31");
    end
  endtask

  task automatic t_holdoff();
    int exp;
    int n;
    model_next(0, exp);
    @(negedge clk);
    req_i   = 1'b1;
    wired_i = '0;
    @(negedge clk);
    wired_i = CNT_W'(ENT - 1);
    for (int i = 0; i < 6; i++) begin
      check(busy_o == 1'b1, "R7 busy during hold-off", int'(busy_o), 1);
      @(negedge clk);
    end
    req_i = 1'b0;
    n = 0;
    while (!valid_o && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(int'(idx_o) == exp, "R7 held requests ignored", int'(idx_o), exp);
    @(negedge clk);
    check(busy_o == 1'b0, "R7 no extra run", int'(busy_o), 0);
    draw(3, "R7 sequence unchanged after hold-off");
  endtask

  initial begin
    checks  = 0;
    errors  = 0;
    cycles  = 0;
    m_lfsr  = 32'h1;
    m_last  = 0;
    rst_n   = 1'b0;
    req_i   = 1'b0;
    wired_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_range();
    t_mid_wired();
    t_clamp();
    t_holdoff();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule